// File: doc/BRIEF.md
# Jump and Branch Target Unit

This unit works out where control goes after a control-transfer instruction. It also works out whether a return address must be saved. It takes the address of the current instruction, the first and second instruction halfwords, the value of the first source register and the four condition flags. One cycle later it reports whether the transfer is taken, the next program counter, and an optional link write (the register index and the value).

Four kinds of transfer are recognised:

- a jump through a register;
- a PC-relative jump with a 22-bit displacement;
- the same relative jump with a link write of the return address (PC+4);
- a conditional branch with a 9-bit displacement.

Both displacements are spread over non-adjacent instruction fields and have an implied zero low bit. Any other halfword passes through as straight-line code with a next PC of PC+2. Flushing, fetch and memory access belong to the surrounding pipeline.

Top module: `jump_target_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `validOut`, `takenOut` and `linkWeOut` are low.
- R2: A first halfword whose bits 15:5 equal 00000000011 is a register jump. It is taken, its target is the full `reg1In` value with bit 0 untouched, and it writes no link.
- R3: A first halfword whose bits 10:6 equal 11110 is a 22-bit relative jump. Its displacement is {hw0[5:0], hw1[15:1], 0}, sign-extended from bit 21. The target is `pcIn` plus that displacement, and hw1 bit 0 has no effect.
- R4: For the 22-bit form with a nonzero field in hw0[15:11], the unit raises `linkWeOut`. It sets `linkIdxOut` to that field and `linkValOut` to `pcIn`+4.
- R5: For the 22-bit form with hw0[15:11] equal to zero, the jump is still taken but `linkWeOut` stays low.
- R6: A first halfword whose bits 10:7 equal 1011 is a conditional branch. Its displacement is {hw0[15:11], hw0[6:4], 0}, sign-extended from bit 8. When taken, its target is `pcIn` plus that displacement.
- R7: The branch condition is hw0[3:0], and the flag positions are `flagsIn`[0]=Z, [1]=S, [2]=OV, [3]=CY. Codes 0, 1, 2 and 3 test OV, CY, Z and S set, and code 5 is always. Codes 8, 9, A, B and D are the inverses of those. Codes 4, 6, 7, C, E and F are never taken.
- R8: A branch whose condition fails has `takenOut` low and a target of `pcIn`+2.
- R9: A first halfword matching none of the three patterns gives `takenOut` low, `linkWeOut` low and a target of `pcIn`+2.
- R10: Results appear exactly one cycle after `validIn` is sampled high, in input order. When `validOut` is low, `takenOut` and `linkWeOut` are low.
- R11: All target and link arithmetic wraps modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Inputs hold an instruction to evaluate |
| pcIn | input | XLEN | Address of the current instruction |
| hw0In | input | 16 | First instruction halfword |
| hw1In | input | 16 | Second instruction halfword (22-bit forms only) |
| reg1In | input | XLEN | Value of the source register for the register jump |
| flagsIn | input | 4 | Condition flags {CY, OV, S, Z} |
| validOut | output | 1 | Result registers hold a result |
| takenOut | output | 1 | Control transfer is taken |
| targetPcOut | output | XLEN | Next program counter |
| linkWeOut | output | 1 | Write the link value to a register |
| linkIdxOut | output | 5 | Register index for the link write |
| linkValOut | output | XLEN | Return address to be written |

## Verification
A jump-and-link does a jump and a link write in the same cycle. The link path and the relative-target path use separate adders fed from the same PC. The bench sends jump-and-link instructions at PCs near the top of the address space, so that the target add and the PC+4 add both carry out of the top bit at once. It also sends them back to back with branches, and the scoreboard compares the taken flag, the target, the link index and the link value of each result against one expected item. A second overlap sits between a failed branch and the sequential path. The bench sweeps all sixteen condition codes against all sixteen flag patterns, and each result is judged on both the taken flag and the PC+2 or branch target.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

  localparam int HW_W      = 16;
  localparam int REG_IDX_W = 5;
  localparam int FLAG_W    = 4;
  localparam int DISP22_W  = 22;
  localparam int DISP9_W   = 9;

  // flag bit positions inside flagsIn
  localparam int FLAG_Z  = 0;
  localparam int FLAG_S  = 1;
  localparam int FLAG_OV = 2;
  localparam int FLAG_CY = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic selReg;     // target from register operand
    logic selRel22;   // target from 22-bit relative displacement
    logic selRel9;    // conditional branch with 9-bit displacement
    logic condHolds;  // branch condition satisfied
    logic linkEn;     // issue link write
  } jtu_strobe_t;

endpackage

// File: rtl/jtu_cond.sv
module jtu_cond
  import jtu_pkg::*;
(
  input  logic [3:0]        condCode,
  input  logic [FLAG_W-1:0] flags,
  output logic              holds
);

  logic baseVal;
  logic legalCode;

  always_comb begin
    legalCode = 1'b1;
    baseVal   = 1'b0;
    unique case (condCode[2:0])
      3'd0: baseVal = flags[FLAG_OV];
      3'd1: baseVal = flags[FLAG_CY];
      3'd2: baseVal = flags[FLAG_Z];
      3'd3: baseVal = flags[FLAG_S];
      3'd5: baseVal = 1'b1;
      default: legalCode = 1'b0;
    endcase
  end

  // bit 3 inverts the sense of the test
  assign holds = legalCode & (baseVal ^ condCode[3]);

endmodule

// File: rtl/jtu_ctrl.sv
module jtu_ctrl
  import jtu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [HW_W-1:0]   hw0In,
  input  logic [FLAG_W-1:0] flagsIn,
  output jtu_strobe_t       strobes
);

  localparam logic [10:0] REG_JUMP_KEY = 11'b000_0000_0011;
  localparam logic [4:0]  REL22_KEY    = 5'b11110;
  localparam logic [3:0]  REL9_KEY     = 4'b1011;

  logic isRegJump;
  logic isRel22;
  logic isRel9;
  logic destNonZero;
  logic condOk;

  assign isRegJump   = (hw0In[15:5] == REG_JUMP_KEY);
  assign isRel22     = (hw0In[10:6] == REL22_KEY);
  assign isRel9      = (hw0In[10:7] == REL9_KEY);
  assign destNonZero = (hw0In[15:11] != '0);

  jtu_cond u_cond (
    .condCode (hw0In[3:0]),
    .flags    (flagsIn),
    .holds    (condOk)
  );

  always_comb begin
    strobes           = '0;
    strobes.selReg    = isRegJump;
    strobes.selRel22  = isRel22 & ~isRegJump;
    strobes.selRel9   = isRel9 & ~isRel22 & ~isRegJump;
    strobes.condHolds = condOk;
    strobes.linkEn    = isRel22 & ~isRegJump & destNonZero;
  end

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selReg, strobes.selRel22, strobes.selRel9}));

  // R7
  never_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hw0In[2:0] == 3'd4 || hw0In[2:0] == 3'd6 || hw0In[2:0] == 3'd7) |-> !condOk);

  // R5
  link_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.linkEn |-> (strobes.selRel22 && hw0In[15:11] != 5'd0));

endmodule

// File: rtl/jtu_dpath.sv
module jtu_dpath
  import jtu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic [XLEN-1:0]      pcIn,
  input  logic [HW_W-1:0]      hw0In,
  input  logic [HW_W-1:0]      hw1In,
  input  logic [XLEN-1:0]      reg1In,
  input  jtu_strobe_t          strobes,
  output logic                 validOut,
  output logic                 takenOut,
  output logic [XLEN-1:0]      targetPcOut,
  output logic                 linkWeOut,
  output logic [REG_IDX_W-1:0] linkIdxOut,
  output logic [XLEN-1:0]      linkValOut
);

  localparam int EXT22_W = XLEN - DISP22_W;
  localparam int EXT9_W  = XLEN - DISP9_W;
  localparam logic [XLEN-1:0] SEQ_STEP  = XLEN'(2);
  localparam logic [XLEN-1:0] LINK_STEP = XLEN'(4);

  logic [DISP22_W-1:0] disp22;
  logic [DISP9_W-1:0]  disp9;
  logic [XLEN-1:0]     offset;
  logic [XLEN-1:0]     relTarget;
  logic [XLEN-1:0]     seqPc;
  logic [XLEN-1:0]     linkPc;
  logic                takeRel;
  logic                takeNxt;
  logic [XLEN-1:0]     targetNxt;
  logic                unusedDpBits;

  assign unusedDpBits = ^{hw0In[10:7], hw0In[3:0], hw1In[0]};

  // scattered displacement fields, implied zero low bit
  assign disp22 = {hw0In[5:0], hw1In[15:1], 1'b0};
  assign disp9  = {hw0In[15:11], hw0In[6:4], 1'b0};

  assign offset = strobes.selRel22 ? {{EXT22_W{disp22[DISP22_W-1]}}, disp22}
                                   : {{EXT9_W{disp9[DISP9_W-1]}}, disp9};

  assign relTarget = pcIn + offset;
  assign seqPc     = pcIn + SEQ_STEP;
  assign linkPc    = pcIn + LINK_STEP;

  assign takeRel   = strobes.selRel22 | (strobes.selRel9 & strobes.condHolds);
  assign takeNxt   = strobes.selReg | takeRel;

  always_comb begin
    if (strobes.selReg)  targetNxt = reg1In;
    else if (takeRel)    targetNxt = relTarget;
    else                 targetNxt = seqPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut    <= 1'b0;
      takenOut    <= 1'b0;
      targetPcOut <= '0;
      linkWeOut   <= 1'b0;
      linkIdxOut  <= '0;
      linkValOut  <= '0;
    end else begin
      validOut    <= validIn;
      takenOut    <= validIn & takeNxt;
      targetPcOut <= targetNxt;
      linkWeOut   <= validIn & strobes.linkEn;
      linkIdxOut  <= hw0In[15:11];
      linkValOut  <= linkPc;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> (!takenOut && !linkWeOut));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  // R4
  link_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWeOut |-> (takenOut && linkIdxOut != '0));

  // R8
  seq_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !strobes.selReg && !strobes.selRel22 && !(strobes.selRel9 && strobes.condHolds))
      |=> (targetPcOut == $past(pcIn) + SEQ_STEP));

endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
  import jtu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic [XLEN-1:0]      pcIn,
  input  logic [HW_W-1:0]      hw0In,
  input  logic [HW_W-1:0]      hw1In,
  input  logic [XLEN-1:0]      reg1In,
  input  logic [FLAG_W-1:0]    flagsIn,
  output logic                 validOut,
  output logic                 takenOut,
  output logic [XLEN-1:0]      targetPcOut,
  output logic                 linkWeOut,
  output logic [REG_IDX_W-1:0] linkIdxOut,
  output logic [XLEN-1:0]      linkValOut
);

  jtu_strobe_t strobes;

  jtu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hw0In   (hw0In),
    .flagsIn (flagsIn),
    .strobes (strobes)
  );

  jtu_dpath #(.XLEN(XLEN)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .validIn     (validIn),
    .pcIn        (pcIn),
    .hw0In       (hw0In),
    .hw1In       (hw1In),
    .reg1In      (reg1In),
    .strobes     (strobes),
    .validOut    (validOut),
    .takenOut    (takenOut),
    .targetPcOut (targetPcOut),
    .linkWeOut   (linkWeOut),
    .linkIdxOut  (linkIdxOut),
    .linkValOut  (linkValOut)
  );

endmodule

// File: tb/jump_target_unit_tb.sv
module jump_target_unit_tb;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            validIn = 1'b0;
  logic [XLEN-1:0] pcIn = '0;
  logic [15:0]     hw0In = '0;
  logic [15:0]     hw1In = '0;
  logic [XLEN-1:0] reg1In = '0;
  logic [3:0]      flagsIn = '0;
  logic            validOut;
  logic            takenOut;
  logic [XLEN-1:0] targetPcOut;
  logic            linkWeOut;
  logic [4:0]      linkIdxOut;
  logic [XLEN-1:0] linkValOut;

  int checks = 0;
  int fails  = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  typedef struct packed {
    logic            taken;
    logic [XLEN-1:0] target;
    logic            lwe;
    logic [4:0]      lidx;
    logic [XLEN-1:0] lval;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  jump_target_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .pcIn(pcIn), .hw0In(hw0In),
    .hw1In(hw1In), .reg1In(reg1In), .flagsIn(flagsIn), .validOut(validOut),
    .takenOut(takenOut), .targetPcOut(targetPcOut), .linkWeOut(linkWeOut),
    .linkIdxOut(linkIdxOut), .linkValOut(linkValOut)
  );

  task automatic check(input string tag, input string what, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // condition table, flags {CY,OV,S,Z}
  function automatic logic condRef(input logic [3:0] c, input logic [3:0] f);
    case (c)
      4'h0: return f[2];
      4'h8: return !f[2];
      4'h1: return f[3];
      4'h9: return !f[3];
      4'h2: return f[0];
      4'hA: return !f[0];
      4'h3: return f[1];
      4'hB: return !f[1];
      4'h5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic exp_t model(input logic [XLEN-1:0] pc, input logic [15:0] h0,
                                 input logic [15:0] h1, input logic [XLEN-1:0] r1,
                                 input logic [3:0] f);
    exp_t e;
    int signed d;
    e = '0;
    e.target = pc + 32'd2;
    if (h0[15:5] == 11'b00000000011) begin
      e.taken = 1'b1;
      e.target = r1;
    end else if (h0[10:6] == 5'b11110) begin
      d = int'({h0[5:0], h1[15:1], 1'b0});
      if (d >= (1 << 21)) d = d - (1 << 22);
      e.taken = 1'b1;
      e.target = pc + 32'(d);
      if (h0[15:11] != 0) begin
        e.lwe = 1'b1;
        e.lidx = h0[15:11];
        e.lval = pc + 32'd4;
      end
    end else if (h0[10:7] == 4'b1011) begin
      d = int'({h0[15:11], h0[6:4], 1'b0});
      if (d >= 256) d = d - 512;
      if (condRef(h0[3:0], f)) begin
        e.taken = 1'b1;
        e.target = pc + 32'(d);
      end
    end
    return e;
  endfunction

  task automatic send(input string tag, input logic [XLEN-1:0] pc, input logic [15:0] h0,
                      input logic [15:0] h1, input logic [XLEN-1:0] r1, input logic [3:0] f);
    @(negedge clk);
    validIn = 1'b1; pcIn = pc; hw0In = h0; hw1In = h1; reg1In = r1; flagsIn = f;
    expQ.push_back(model(pc, h0, h1, r1, f));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn = 1'b0;
      hw0In = 16'hFFFF;
    end
  endtask

  function automatic logic [15:0] encJ22H0(input logic [4:0] dst, input logic [21:0] d);
    return {dst, 5'b11110, d[21:16]};
  endfunction
  function automatic logic [15:0] encJ22H1(input logic [21:0] d, input logic lsb);
    return {d[15:1], lsb};
  endfunction
  function automatic logic [15:0] encBr(input logic [3:0] c, input logic [8:0] d);
    return {d[8:4], 4'b1011, d[3:1], c};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (validOut) begin
        if (expQ.size() == 0) begin
          check("R10", "unexpected result", 32'd1, 32'd0);
        end else begin
          exp_t e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, "taken", 32'(takenOut), 32'(e.taken));
          check(t, "target", targetPcOut, e.target);
          check(t, "linkWe", 32'(linkWeOut), 32'(e.lwe));
          if (e.lwe) begin
            check(t, "linkIdx", 32'(linkIdxOut), 32'(e.lidx));
            check(t, "linkVal", linkValOut, e.lval);
          end
        end
      end else begin
        check("R10", "idle taken/linkWe", 32'({takenOut, linkWeOut}), 32'd0);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [3:0] fl;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset outputs", 32'({validOut, takenOut, linkWeOut}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "after reset", 32'({validOut, takenOut, linkWeOut}), 32'd0);
    running = 1'b1;

    // R2 register jump, odd target kept
    send("R2", 32'h0000_1000, {11'b00000000011, 5'd5}, 16'h0, 32'h1234_5679, 4'h0);
    send("R2", 32'h0000_2000, {11'b00000000011, 5'd31}, 16'hFFFF, 32'hFFFF_FFFE, 4'hF);
    idle(2);
    // R3 forward and backward, hw1 bit0 ignored; R5 dest zero
    send("R3", 32'h0000_4000, encJ22H0(5'd0, 22'h0ABCDE), encJ22H1(22'h0ABCDE, 1'b1), 32'h0, 4'h0);
    send("R5", 32'h0000_4000, encJ22H0(5'd0, 22'h3FFF00), encJ22H1(22'h3FFF00, 1'b0), 32'h0, 4'h0);
    send("R3", 32'h0040_0000, encJ22H0(5'd0, 22'h200000), encJ22H1(22'h200000, 1'b1), 32'h0, 4'h0);
    // R4 jump-and-link
    send("R4", 32'h0000_8000, encJ22H0(5'd31, 22'h000010), encJ22H1(22'h000010, 1'b0), 32'h0, 4'h0);
    send("R4", 32'h0000_8002, encJ22H0(5'd1, 22'h3FFFFE), encJ22H1(22'h3FFFFE, 1'b1), 32'h0, 4'h0);
    // R11 wraps of target and link, same cycle
    send("R11", 32'hFFFF_FFF0, encJ22H0(5'd7, 22'h000020), encJ22H1(22'h000020, 1'b0), 32'h0, 4'h0);
    send("R11", 32'hFFFF_FFFE, encJ22H0(5'd9, 22'h000004), encJ22H1(22'h000004, 1'b0), 32'h0, 4'h0);
    send("R11", 32'h0000_0004, encBr(4'h5, 9'h1F0), 16'h0, 32'h0, 4'h0);
    idle(1);
    // R6 R7 R8 all codes against all flags
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        fl = 4'(f);
        send("R7", 32'h0001_0000 + 32'(c * 64), encBr(4'(c), (f % 2 == 0) ? 9'h0FE : 9'h100),
             16'h0, 32'h0, fl);
      end
      idle(1);
    end
    send("R6", 32'h0000_0100, encBr(4'h5, 9'h0FE), 16'h0, 32'h0, 4'h0);
    send("R8", 32'h0000_0100, encBr(4'hD, 9'h0FE), 16'h0, 32'h0, 4'h0);
    // R4 back-to-back with branches
    send("R4", 32'h7FFF_FFFC, encJ22H0(5'd2, 22'h1FFFFE), encJ22H1(22'h1FFFFE, 1'b0), 32'h0, 4'h0);
    send("R8", 32'h7FFF_FFFC, encBr(4'h2, 9'h002), 16'h0, 32'h0, 4'h0);
    // R9 non-control halfwords
    send("R9", 32'h0000_3000, 16'h0000, 16'h0, 32'hDEAD_BEEF, 4'hF);
    send("R9", 32'h0000_3002, 16'h1234, 16'h0, 32'hDEAD_BEEF, 4'hF);
    send("R9", 32'hFFFF_FFFE, 16'hFFFF, 16'hFFFF, 32'hDEAD_BEEF, 4'hF);
    idle(3);
    // R10 all results consumed
    check("R10", "pending results", 32'(expQ.size()), 32'd0);
    running = 1'b0;
    summary();
  end

endmodule